// File: doc/BRIEF.md
# GF(16) Horner Polynomial Evaluator

This block evaluates a degree-14 polynomial with coefficients in GF(16) at one field element. The fifteen 4-bit coefficients come in together in a single 60-bit word, and the evaluation point is a 4-bit element. The computation uses Horner's rule. Each of the fourteen multiply-accumulate steps has its own registered pipeline stage, so the block accepts a new (point, coefficients) pair on every clock.

Every stage keeps its own copies of three things: the partial sum, the evaluation point, and the coefficients not yet consumed. Evaluations that are in flight together therefore never share state. A valid flag travels alongside the data. The result for an accepted input comes out fourteen cycles later with `result_valid` high. Field multiplication is a combinational polynomial-basis multiplier reduced by x^4 + x + 1. Field addition is a bitwise XOR.

Top module: `gf16_horner_eval`

## Requirements
- R1: Field multiplication uses polynomial basis with the reduction polynomial x^4 + x + 1 (0x13). For example, 8·8 = 0xC, and the coefficient word with only coefficient 1 set to 1 yields x itself.
- R2: The coefficient word packs coefficient k (the factor of x^k) in bits [4k+3:4k]. Coefficient 14 is therefore in bits 59:56 and coefficient 0 is in bits 3:0.
- R3: `result` equals the XOR over k = 0..14 of coef_k · x^k, computed in GF(16).
- R4: For an input accepted at a rising edge (in_valid high), `result` and `result_valid` show its outcome after the 14th rising edge counted from that edge inclusive. That is 14 cycles after the input was presented.
- R5: An input can be accepted on every clock cycle. Back-to-back inputs give back-to-back results in the same order.
- R6: `result_valid` is high in a cycle exactly when the input presented 14 cycles earlier had in_valid high. Gaps in in_valid appear as identical gaps at the output.
- R7: A rising edge with rst_n low clears every valid flag. `result_valid` is low after that edge, and it stays low until an input accepted after reset has reached the output.
- R8: When x = 0 the result equals coefficient 0.
- R9: When x = 1 the result equals the XOR of all fifteen coefficients.
- R10: Each evaluation uses only its own x and coefficients, even when neighbouring evaluations in the pipeline have different values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accept x_in and coef_in on this edge |
| x_in | input | 4 | Evaluation point in GF(16) |
| coef_in | input | 60 | Packed coefficients, coefficient k in bits [4k+3:4k] |
| result | output | 4 | Polynomial value at the evaluation point |
| result_valid | output | 1 | result belongs to an accepted input |

## Verification
Suppose a stage uses the wrong copy of x, or shifts the coefficient slice by one nibble. Only the affected evaluations show a wrong `result`, exactly 14 cycles after their inputs. Random back-to-back traffic with a different x every cycle exposes such mixing at once, and the x = 0 and x = 1 cases separate coefficient-order faults from multiplier faults. A broken valid chain shows up as a misplaced or missing `result_valid` in the same cycle window, and it is checked on every clock, including the cycles right after a reset in mid-stream.

// File: rtl/gf16_pkg.sv
// Shared field definitions for the GF(16) evaluator.
// Assumes polynomial basis with a fixed reduction polynomial of degree 4.
package gf16_pkg;
    localparam int SYM_W = 4;
    localparam logic [SYM_W:0] FIELD_POLY = 5'h13;
    typedef logic [SYM_W-1:0] gf_sym_t;
endpackage

// File: rtl/gf16_mul.sv
// Combinational GF(2^W) multiplier in polynomial basis.
// Builds a·x^i for each bit i of b by repeated reduced shifts, then XORs the
// terms selected by b. Assumes POLY holds the full reduction polynomial,
// including its leading bit.
module gf16_mul #(
    parameter int W = 4,
    parameter logic [W:0] POLY = 5'h13
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);
    logic [W-1:0] a_pow [W];
    logic [W-1:0] part  [W];

    assign a_pow[0] = a;
    assign part[0]  = b[0] ? a : '0;

    for (genvar i = 1; i < W; i++) begin : g_term
        // multiply the previous power by x and reduce
        assign a_pow[i] = {a_pow[i-1][W-2:0], 1'b0}
                        ^ (a_pow[i-1][W-1] ? POLY[W-1:0] : '0);
        // accumulate the selected term
        assign part[i] = part[i-1] ^ (b[i] ? a_pow[i] : '0);
    end

    assign p = part[W-1];
endmodule

// File: rtl/gf16_pipe_reg.sv
// Enable-loaded pipeline register with no reset, used for data that only
// matters while its companion valid flag is set.
module gf16_pipe_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // capture data only for accepted evaluations
    always_ff @(posedge clk) begin
        if (en) q <= d;
    end
endmodule

// File: rtl/gf16_horner_step.sv
// One Horner step: acc_q <= acc_in·x_in XOR q_in, plus its valid flag.
// The data register loads only when vld_in is set; synchronous active-low
// reset clears only the valid flag.
module gf16_horner_step
    import gf16_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    vld_in,
    input  gf_sym_t acc_in,
    input  gf_sym_t x_in,
    input  gf_sym_t q_in,
    output logic    vld_q,
    output gf_sym_t acc_q
);
    gf_sym_t prod;
    gf_sym_t sum;

    gf16_mul #(.W(SYM_W), .POLY(FIELD_POLY)) u_mul (
        .a (acc_in),
        .b (x_in),
        .p (prod)
    );

    assign sum = prod ^ q_in;

    // valid flag follows the upstream flag, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_in;
    end

    // partial sum register, loaded for accepted evaluations only
    always_ff @(posedge clk) begin
        if (vld_in) acc_q <= sum;
    end
endmodule

// File: rtl/gf16_horner_eval.sv
// Fully pipelined GF(16) polynomial evaluator using Horner's rule.
// Stage k consumes one coefficient, working from coefficient DEGREE-1 down
// to 0; coefficient DEGREE seeds the accumulator. Every stage registers
// its partial sum, its copy of x and the coefficients still to be used,
// so one evaluation is accepted per clock and leaves DEGREE cycles later.
// Assumes DEGREE >= 2.
module gf16_horner_eval
    import gf16_pkg::*;
#(
    parameter int DEGREE = 14,
    localparam int COEF_W = (DEGREE + 1) * SYM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SYM_W-1:0]  x_in,
    input  logic [COEF_W-1:0] coef_in,
    output logic [SYM_W-1:0]  result,
    output logic              result_valid
);
    // bit offset of stage k's remaining-coefficient slice in rem_bus
    function automatic int rem_off(input int k);
        return SYM_W * (k * (DEGREE - 1) - (k * (k - 1)) / 2);
    endfunction

    localparam int REM_BUS_W = rem_off(DEGREE - 1);

    wire  [DEGREE-1:0]    stage_vld;
    gf_sym_t              stage_acc [DEGREE];
    gf_sym_t              stage_x   [DEGREE-1];
    wire  [REM_BUS_W-1:0] rem_bus;

    for (genvar k = 0; k < DEGREE; k++) begin : g_stage
        localparam int SRC_W = (DEGREE - k) * SYM_W;

        logic [SRC_W-1:0] rem_src;
        gf_sym_t          acc_src;
        gf_sym_t          x_src;
        logic             vld_src;

        if (k == 0) begin : g_head
            assign rem_src = coef_in[SRC_W-1:0];
            assign acc_src = coef_in[COEF_W-1 -: SYM_W];
            assign x_src   = x_in;
            assign vld_src = in_valid;
        end else begin : g_body
            assign rem_src = rem_bus[rem_off(k-1) +: SRC_W];
            assign acc_src = stage_acc[k-1];
            assign x_src   = stage_x[k-1];
            assign vld_src = stage_vld[k-1];
        end

        gf16_horner_step u_step (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_in (vld_src),
            .acc_in (acc_src),
            .x_in   (x_src),
            .q_in   (rem_src[SRC_W-1 -: SYM_W]),
            .vld_q  (stage_vld[k]),
            .acc_q  (stage_acc[k])
        );

        if (k < DEGREE - 1) begin : g_carry
            localparam int NEXT_W = (DEGREE - 1 - k) * SYM_W;

            gf16_pipe_reg #(.W(SYM_W)) u_x (
                .clk (clk),
                .en  (vld_src),
                .d   (x_src),
                .q   (stage_x[k])
            );

            gf16_pipe_reg #(.W(NEXT_W)) u_rem (
                .clk (clk),
                .en  (vld_src),
                .d   (rem_src[NEXT_W-1:0]),
                .q   (rem_bus[rem_off(k) +: NEXT_W])
            );
        end
    end

    assign result       = stage_acc[DEGREE-1];
    assign result_valid = stage_vld[DEGREE-1];
endmodule

// File: rtl/gf16_horner_eval_chk.sv
// Assertion checker for gf16_horner_eval, attached by bind below.
module gf16_horner_eval_chk #(
    parameter int DEGREE = 14,
    parameter int SYM_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [SYM_W-1:0] x_in,
    input logic             result_valid,
    input logic [DEGREE-1:0] stage_vld,
    input logic [SYM_W-1:0] stage_x [DEGREE-1]
);
    localparam int CNT_W = $clog2(DEGREE + 1);

    logic [CNT_W-1:0] since_rst;

    // count cycles since reset, saturating at the pipeline depth
    always_ff @(posedge clk) begin
        if (!rst_n)                               since_rst <= '0;
        else if (since_rst != CNT_W'(DEGREE))     since_rst <= since_rst + 1'b1;
    end

    // R7
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stage_vld == '0 && !result_valid));

    // R4
    min_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (since_rst == CNT_W'(DEGREE)));

    // R6
    head_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != '0) |-> (stage_vld[0] == $past(in_valid)));

    for (genvar k = 1; k < DEGREE; k++) begin : g_vchk
        // R6
        vld_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stage_vld[k] |-> $past(stage_vld[k-1]));
    end

    // R10
    head_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_vld[0] |-> (stage_x[0] == $past(x_in)));

    for (genvar k = 1; k < DEGREE - 1; k++) begin : g_xchk
        // R10
        x_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stage_vld[k] |-> (stage_x[k] == $past(stage_x[k-1])));
    end
endmodule

bind gf16_horner_eval gf16_horner_eval_chk #(
    .DEGREE (DEGREE),
    .SYM_W  (gf16_pkg::SYM_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .x_in         (x_in),
    .result_valid (result_valid),
    .stage_vld    (stage_vld),
    .stage_x      (stage_x)
);

// File: tb/gf16_horner_eval_test.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural queue model of the 14-cycle pipeline,
// compared against the outputs at every falling edge.
module gf16_horner_eval_test;
    localparam int DEG = 14;
    localparam int CW  = (DEG + 1) * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    x_in = '0;
    logic [CW-1:0] coef_in = '0;
    logic [3:0]    result;
    logic          result_valid;

    int n_tests = 0;
    int n_fail  = 0;
    string tag = "R7";

    logic       exp_v = 1'b0;
    logic [3:0] exp_r = '0;
    logic [4:0] mq [$];

    gf16_horner_eval uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .x_in         (x_in),
        .coef_in      (coef_in),
        .result       (result),
        .result_valid (result_valid)
    );

    always #10 clk = ~clk;

    function automatic logic [3:0] ref_mul(input logic [3:0] a, input logic [3:0] b);
        logic [6:0] p = '0;
        for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (7'(a) << i);
        for (int j = 6; j >= 4; j--) if (p[j]) p = p ^ (7'h13 << (j - 4));
        return p[3:0];
    endfunction

    // sum of coef_k * x^k, powers built up one at a time
    function automatic logic [3:0] ref_eval(input logic [3:0] x, input logic [CW-1:0] c);
        logic [3:0] pw = 4'h1;
        logic [3:0] s  = '0;
        for (int k = 0; k <= DEG; k++) begin
            s  = s ^ ref_mul(c[k*4 +: 4], pw);
            pw = ref_mul(pw, x);
        end
        return s;
    endfunction

    // reference pipeline: entries leave 13 pushes after entering
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            for (int i = 0; i < DEG - 1; i++) mq.push_back(5'b0);
            exp_v <= 1'b0;
        end else begin
            logic [4:0] e;
            mq.push_back({in_valid, ref_eval(x_in, coef_in)});
            e = mq.pop_front();
            exp_v <= e[4];
            exp_r <= e[3:0];
        end
    end

    task automatic check_out();
        n_tests++;
        if (result_valid !== exp_v || (exp_v && result !== exp_r)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
                     tag, result_valid, result, exp_v, exp_r);
        end
    endtask

    task automatic cyc(input logic v, input logic [3:0] x, input logic [CW-1:0] c);
        @(negedge clk);
        check_out();
        in_valid = v;
        x_in     = x;
        coef_in  = c;
    endtask

    task automatic drain();
        for (int i = 0; i < DEG + 1; i++) cyc(1'b0, 4'($urandom), {$urandom, $urandom});
    endtask

    function automatic logic [CW-1:0] rnd_coef();
        return {$urandom, $urandom};
    endfunction

    initial begin
        // R7: outputs cleared under reset
        tag = "R7";
        repeat (3) cyc(1'b0, '0, '0);
        rst_n = 1'b1;
        drain();

        // R1: field multiply, x·x with x = 8 gives 0xC, and x itself
        tag = "R1";
        cyc(1'b1, 4'h8, CW'(60'h100));
        cyc(1'b1, 4'h9, CW'(60'h010));
        for (int a = 0; a < 16; a++) cyc(1'b1, 4'(a), CW'(60'h100));
        drain();

        // R2: single-coefficient words locate each nibble
        tag = "R2";
        for (int k = 0; k <= DEG; k++) cyc(1'b1, 4'h2, CW'(60'h1) << (4 * k));
        cyc(1'b1, 4'h3, CW'(60'hF) << 56);
        drain();

        // R8: x = 0 gives coefficient 0
        tag = "R8";
        for (int i = 0; i < 20; i++) cyc(1'b1, 4'h0, rnd_coef());
        drain();

        // R9: x = 1 gives XOR of all coefficients
        tag = "R9";
        for (int i = 0; i < 20; i++) cyc(1'b1, 4'h1, rnd_coef());
        drain();

        // R3 R5 R10: back-to-back random evaluations, x changes every cycle
        tag = "R3/R5/R10";
        for (int i = 0; i < 400; i++) cyc(1'b1, 4'($urandom), rnd_coef());
        drain();

        // R6: random gaps in the input valid
        tag = "R6";
        for (int i = 0; i < 400; i++) cyc(1'($urandom % 3 != 0), 4'($urandom), rnd_coef());
        drain();

        // R4: single pulse appears exactly 14 cycles after presentation
        tag = "R4";
        begin
            int lat = 0;
            cyc(1'b1, 4'h7, rnd_coef());
            cyc(1'b0, 4'h0, '0);
            lat = 1;
            while (!result_valid && lat < 40) begin
                cyc(1'b0, 4'h0, '0);
                lat++;
            end
            n_tests++;
            if (lat != DEG) begin
                n_fail++;
                $display("FAIL R4: latency=%0d expected=%0d", lat, DEG);
            end
        end
        drain();

        // R7: reset in mid-stream drops everything in flight
        tag = "R7";
        for (int i = 0; i < 8; i++) cyc(1'b1, 4'($urandom), rnd_coef());
        @(negedge clk);
        check_out();
        rst_n = 1'b0;
        @(negedge clk);
        check_out();
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) cyc(1'b1, 4'($urandom), rnd_coef());
        drain();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule